// File: doc/BRIEF.md
# 6502 Effective Address and Cycle Penalty Unit

This unit turns the operand bytes of a 6502 instruction into the address the instruction acts on, together with the program counter that follows it and the extra cycles the access costs. The sequencer pulses `start` with the addressing mode, the one or two operand bytes, the X and Y index registers, the address of the first operand byte, the access kind (read versus store or read-modify-write) and, for branches, whether the branch condition holds. Modes that need no memory reply finish one cycle later. The two pointer-based modes, (indirect,X) and (indirect),Y, fetch a two-byte pointer from page zero through a request/acknowledge read port and finish once the second byte has arrived.

For relative branches the unit produces the branch target and the total branch cost. For the other modes it reports the penalty that is added on top of the base cost of the instruction. Opcode decode, the ALU and memory are outside the unit.

Top module: `eaddr_unit`

## Requirements
- R1: Mode codes are 0 immediate, 1 zero page, 2 zero page X, 3 zero page Y, 4 absolute, 5 absolute X, 6 absolute Y, 7 (indirect,X), 8 (indirect),Y, 9 relative, and any other code acts as immediate. For absolute the address is op_hi*256+op_lo, next_pc is pc+2 and cycles is 0. For immediate the address is pc, next_pc is pc+1 and cycles is 0. For zero page the address is op_lo with a zero high byte, next_pc is pc+1 and cycles is 0.
- R2: For absolute X and absolute Y the address is {op_hi,op_lo} plus the zero-extended index, taken modulo 65536, and next_pc is pc+2.
- R3: For a read in absolute X, absolute Y or (indirect),Y, cycles is 1 when the index is greater than the low byte of the resulting address, which means a page boundary was crossed. Otherwise it is 0.
- R4: For a store or read-modify-write (is_read=0) in absolute X, absolute Y or (indirect),Y, cycles is always 1.
- R5: For zero page X and zero page Y the address is (op_lo+index) mod 256, with a high byte of zero.
- R6: For (indirect,X) the pointer location is (op_lo+X) mod 256. The address is {byte at location+1, byte at location}, cycles is 0 and next_pc is pc+1.
- R7: For (indirect),Y the pointer location is op_lo. The address is the 16-bit pointer plus Y, modulo 65536, and next_pc is pc+1.
- R8: The high pointer byte is read from (location+1) mod 256, so a pointer at 0xFF takes its high byte from 0x00.
- R9: A relative branch with br_taken=0 gives next_pc = ea = pc+1 and cycles = 2.
- R10: A relative branch with br_taken=1 gives next_pc = ea = pc+1 plus the sign-extended op_lo, modulo 65536. Cycles is 3, or 4 when the high byte of the target differs from the high byte of pc+1.
- R11: The unit reads the low pointer byte first and the high byte second. zp_req stays high with zp_addr stable until zp_ack arrives, and each byte is taken in the cycle where zp_req and zp_ack are both high.
- R12: For modes without a pointer fetch, done rises in the first cycle after the start edge. done is always a single-cycle pulse, and ea, next_pc and cycles are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (sampled when idle) |
| mode | input | 4 | Addressing mode code (R1) |
| op_lo | input | 8 | First operand byte, or the branch offset |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the first operand byte |
| is_read | input | 1 | 1 for a read, 0 for a store or read-modify-write |
| br_taken | input | 1 | Branch condition holds |
| zp_req | output | 1 | Zero-page read request |
| zp_addr | output | 8 | Zero-page read address |
| zp_ack | input | 1 | Read data valid |
| zp_rdata | input | 8 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address (branch target for relative) |
| next_pc | output | 16 | Address of the next instruction |
| cycles | output | 3 | Penalty cycles, or total cycles for a branch |

## Verification
The indexed modes are tried with bases and indices chosen so that some sums stay in the page and some carry into the next page, and one sum wraps past 0xFFFF. The bench compares the read penalty with the fixed store penalty for the same address. The zero-page modes use sums above 0xFF, which separates wrapping in page zero from a 16-bit add. The pointer modes run with immediate and delayed acknowledges and with a pointer at 0xFF, which exposes bad byte order, a handshake that loses data and a missing page-zero wrap of the high byte. Branches cover the not-taken case, forward and backward targets inside the page, and targets that cross a page in each direction.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

    localparam int unsigned EA_DW = 8;
    localparam int unsigned EA_AW = 2 * EA_DW;
    localparam int unsigned EA_CW = 3;
    localparam int unsigned EA_MW = 4;

    typedef enum logic [EA_MW-1:0] {
        M_IMM  = 4'd0,
        M_ZP   = 4'd1,
        M_ZPX  = 4'd2,
        M_ZPY  = 4'd3,
        M_ABS  = 4'd4,
        M_ABSX = 4'd5,
        M_ABSY = 4'd6,
        M_INDX = 4'd7,
        M_INDY = 4'd8,
        M_REL  = 4'd9
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LO   = 2'd1,
        S_HI   = 2'd2
    } ea_fsm_e;

    typedef struct packed {
        ea_fsm_e           fsm;
        ea_mode_e          mode;
        logic              rd;
        logic [EA_DW-1:0]  ptr;
        logic [EA_DW-1:0]  ptr_lo;
        logic [EA_DW-1:0]  yreg;
        logic [EA_AW-1:0]  ea;
        logic [EA_AW-1:0]  npc;
        logic [EA_CW-1:0]  cyc;
        logic              done;
    } ea_state_t;

endpackage

// File: rtl/eaddr_idx_add.sv
module eaddr_idx_add #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2 * DW
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] sum,
    output logic          crossed
);
    localparam int unsigned PAD = AW - DW;

    always_comb begin
        sum     = base + {{PAD{1'b0}}, idx};
        // the low byte of the sum is below the index exactly when a carry left the page
        crossed = (idx > sum[DW-1:0]);
    end
endmodule

// File: rtl/eaddr_branch.sv
module eaddr_branch #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2 * DW,
    parameter int unsigned CW = 3
) (
    input  logic [AW-1:0] pc_next,
    input  logic [DW-1:0] offset,
    input  logic          taken,
    output logic [AW-1:0] target,
    output logic [CW-1:0] cost
);
    localparam int unsigned PAD = AW - DW;
    localparam logic [CW-1:0] COST_SKIP = CW'(2);
    localparam logic [CW-1:0] COST_TAKE = CW'(3);
    localparam logic [CW-1:0] COST_FAR  = CW'(4);

    logic [AW-1:0] jump;
    logic          far;

    always_comb begin
        jump   = pc_next + {{PAD{offset[DW-1]}}, offset};
        far    = (jump[AW-1:DW] != pc_next[AW-1:DW]);
        target = taken ? jump : pc_next;
        if (!taken)   cost = COST_SKIP;
        else if (far) cost = COST_FAR;
        else          cost = COST_TAKE;
    end
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
    import eaddr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [EA_MW-1:0]   mode,
    input  logic [EA_DW-1:0]   op_lo,
    input  logic [EA_DW-1:0]   op_hi,
    input  logic [EA_DW-1:0]   idx_x,
    input  logic [EA_DW-1:0]   idx_y,
    input  logic [EA_AW-1:0]   pc,
    input  logic               is_read,
    input  logic               br_taken,
    output logic               zp_req,
    output logic [EA_DW-1:0]   zp_addr,
    input  logic               zp_ack,
    input  logic [EA_DW-1:0]   zp_rdata,
    output logic               done,
    output logic [EA_AW-1:0]   ea,
    output logic [EA_AW-1:0]   next_pc,
    output logic [EA_CW-1:0]   cycles
);
    localparam logic [EA_CW-1:0] CYC_NONE  = '0;
    localparam logic [EA_CW-1:0] CYC_ONE   = EA_CW'(1);
    localparam logic [EA_DW-1:0] ZERO_PAGE = '0;

    ea_state_t cur_q, nxt_d;
    ea_mode_e  in_mode;

    logic [EA_AW-1:0] pc_p1, pc_p2;
    logic [EA_AW-1:0] add_base_d, add_sum;
    logic [EA_DW-1:0] add_idx_d;
    logic             add_cross;
    logic [EA_AW-1:0] br_target;
    logic [EA_CW-1:0] br_cost;
    logic             in_hi;

    assign in_mode = ea_mode_e'(mode);
    assign pc_p1   = pc + EA_AW'(1);
    assign pc_p2   = pc + EA_AW'(2);
    assign in_hi   = (cur_q.fsm == S_HI);

    // one shared adder: operand base while idle, fetched pointer during the high-byte fetch
    always_comb begin
        if (in_hi) begin
            add_base_d = {zp_rdata, cur_q.ptr_lo};
            add_idx_d  = cur_q.yreg;
        end else begin
            add_base_d = {op_hi, op_lo};
            add_idx_d  = (in_mode == M_ABSY) ? idx_y : idx_x;
        end
    end

    eaddr_idx_add #(.DW(EA_DW), .AW(EA_AW)) u_add (
        .base    (add_base_d),
        .idx     (add_idx_d),
        .sum     (add_sum),
        .crossed (add_cross)
    );

    eaddr_branch #(.DW(EA_DW), .AW(EA_AW), .CW(EA_CW)) u_br (
        .pc_next (pc_p1),
        .offset  (op_lo),
        .taken   (br_taken),
        .target  (br_target),
        .cost    (br_cost)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.fsm)
            S_IDLE: begin
                if (start) begin
                    nxt_d.mode = in_mode;
                    nxt_d.rd   = is_read;
                    nxt_d.yreg = idx_y;
                    nxt_d.npc  = pc_p1;
                    nxt_d.cyc  = CYC_NONE;
                    nxt_d.done = 1'b1;
                    case (in_mode)
                        M_ZP:  nxt_d.ea = {ZERO_PAGE, op_lo};
                        M_ZPX: nxt_d.ea = {ZERO_PAGE, op_lo + idx_x};
                        M_ZPY: nxt_d.ea = {ZERO_PAGE, op_lo + idx_y};
                        M_ABS: begin
                            nxt_d.ea  = {op_hi, op_lo};
                            nxt_d.npc = pc_p2;
                        end
                        M_ABSX, M_ABSY: begin
                            nxt_d.ea  = add_sum;
                            nxt_d.npc = pc_p2;
                            nxt_d.cyc = (is_read && !add_cross) ? CYC_NONE : CYC_ONE;
                        end
                        M_INDX: begin
                            nxt_d.ptr  = op_lo + idx_x;
                            nxt_d.fsm  = S_LO;
                            nxt_d.done = 1'b0;
                        end
                        M_INDY: begin
                            nxt_d.ptr  = op_lo;
                            nxt_d.fsm  = S_LO;
                            nxt_d.done = 1'b0;
                        end
                        M_REL: begin
                            nxt_d.ea  = br_target;
                            nxt_d.npc = br_target;
                            nxt_d.cyc = br_cost;
                        end
                        default: begin
                            nxt_d.mode = M_IMM;
                            nxt_d.ea   = pc;
                        end
                    endcase
                end
            end
            S_LO: begin
                if (zp_ack) begin
                    nxt_d.ptr_lo = zp_rdata;
                    nxt_d.fsm    = S_HI;
                end
            end
            S_HI: begin
                if (zp_ack) begin
                    nxt_d.fsm  = S_IDLE;
                    nxt_d.done = 1'b1;
                    if (cur_q.mode == M_INDY) begin
                        nxt_d.ea  = add_sum;
                        nxt_d.cyc = (cur_q.rd && !add_cross) ? CYC_NONE : CYC_ONE;
                    end else begin
                        nxt_d.ea  = {zp_rdata, cur_q.ptr_lo};
                        nxt_d.cyc = CYC_NONE;
                    end
                end
            end
            default: nxt_d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{fsm: S_IDLE, mode: M_IMM, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zp_req  = (cur_q.fsm != S_IDLE);
    assign zp_addr = in_hi ? (cur_q.ptr + EA_DW'(1)) : cur_q.ptr;
    assign done    = cur_q.done;
    assign ea      = cur_q.ea;
    assign next_pc = cur_q.npc;
    assign cycles  = cur_q.cyc;

    logic [EA_MW-1:0] chk_mode;
    logic             chk_rd;
    logic             chk_lo;
    assign chk_mode = cur_q.mode;
    assign chk_rd   = cur_q.rd;
    assign chk_lo   = (cur_q.fsm == S_LO);

endmodule

// File: rtl/eaddr_unit_chk.sv
module eaddr_unit_chk
    import eaddr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic [EA_DW-1:0]   ea_hi,
    input logic [EA_CW-1:0]   cycles,
    input logic               zp_req,
    input logic               zp_ack,
    input logic [EA_DW-1:0]   zp_addr,
    input logic [EA_MW-1:0]   mode_q,
    input logic               rd_q,
    input logic               in_lo
);
    // R1: absolute mode carries no penalty
    assert_abs_no_penalty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == M_ABS) |-> (cycles == '0));

    // R4: stores and read-modify-write always pay the indexed penalty
    assert_store_penalty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_q && (mode_q == M_ABSX || mode_q == M_ABSY || mode_q == M_INDY))
        |-> (cycles == EA_CW'(1)));

    // R5: indexed zero-page addresses never leave page zero
    assert_zp_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == M_ZPX || mode_q == M_ZPY)) |-> (ea_hi == '0));

    // R8: high pointer byte comes from the next zero-page location, wrapping
    assert_ptr_hi_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zp_req && zp_ack && in_lo) |=> (zp_req && zp_addr == $past(zp_addr) + EA_DW'(1)));

    // R9 and R10: branch cost lies between two and four cycles
    assert_branch_cost_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == M_REL) |-> (cycles >= EA_CW'(2) && cycles <= EA_CW'(4)));

    // R11: a pending request holds its address until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (zp_req && !zp_ack) |=> (zp_req && $stable(zp_addr)));

    // R12: done is a one-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind eaddr_unit eaddr_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .ea_hi   (ea[15:8]),
    .cycles  (cycles),
    .zp_req  (zp_req),
    .zp_ack  (zp_ack),
    .zp_addr (zp_addr),
    .mode_q  (chk_mode),
    .rd_q    (chk_rd),
    .in_lo   (chk_lo)
);

// File: tb/sim_eaddr_unit.sv
`timescale 1ns/1ps
module sim_eaddr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
    logic [15:0] pc = '0;
    logic        is_read = 1'b1, br_taken = 1'b0;
    logic        zp_req;
    logic [7:0]  zp_addr;
    logic        zp_ack = 1'b0;
    logic [7:0]  zp_rdata = '0;
    logic        done;
    logic [15:0] ea, next_pc;
    logic [2:0]  cycles;

    int errors = 0;
    int checks = 0;
    int lat;
    int mem_lat = 0;
    int wait_cnt = 0;
    int nlog = 0;
    logic [7:0] rd_log [4];
    logic [7:0] zpmem [256];
    int wd = 0;

    always #4 clk = ~clk;

    eaddr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo), .op_hi(op_hi),
        .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .is_read(is_read), .br_taken(br_taken),
        .zp_req(zp_req), .zp_addr(zp_addr), .zp_ack(zp_ack), .zp_rdata(zp_rdata),
        .done(done), .ea(ea), .next_pc(next_pc), .cycles(cycles)
    );

    // zero-page memory model with a programmable acknowledge delay
    always @(negedge clk) begin
        if (zp_ack) begin
            zp_ack = 1'b0;
        end else if (zp_req) begin
            if (wait_cnt >= mem_lat) begin
                zp_ack   = 1'b1;
                zp_rdata = zpmem[zp_addr];
                if (nlog < 4) rd_log[nlog] = zp_addr;
                nlog++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                          input logic rd, input logic tk);
        @(negedge clk);
        mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc = p;
        is_read = rd; br_taken = tk; start = 1'b1;
        nlog = 0; wait_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        if (!done) chk("R12 done timeout", 0, 1);
    endtask

    task automatic t_reset;
        chk("R12 reset done", done, 0);
        chk("R11 reset req", zp_req, 0);
        chk("R12 reset ea", ea, 16'h0000);
        chk("R12 reset cycles", cycles, 0);
    endtask

    task automatic t_direct;
        run_op(4'd4, 8'h34, 8'h12, 8'h00, 8'h00, 16'h8001, 1, 0);
        chk("R1 abs ea", ea, 16'h1234);
        chk("R1 abs npc", next_pc, 16'h8003);
        chk("R1 abs cyc", cycles, 0);
        chk("R12 latency", lat, 1);
        @(negedge clk);
        chk("R12 pulse", done, 0);
        run_op(4'd0, 8'h55, 8'h66, 8'h00, 8'h00, 16'hC0FF, 1, 0);
        chk("R1 imm ea", ea, 16'hC0FF);
        chk("R1 imm npc", next_pc, 16'hC100);
        run_op(4'd1, 8'hA7, 8'h66, 8'h00, 8'h00, 16'h9000, 1, 0);
        chk("R1 zp ea", ea, 16'h00A7);
        chk("R1 zp npc", next_pc, 16'h9001);
        run_op(4'd15, 8'hA7, 8'h66, 8'h00, 8'h00, 16'h9000, 1, 0);
        chk("R1 unused code as imm", ea, 16'h9000);
    endtask

    task automatic t_abs_indexed;
        run_op(4'd5, 8'hF0, 8'h12, 8'h10, 8'h00, 16'h8000, 1, 0);
        chk("R2 absx cross ea", ea, 16'h1300);
        chk("R3 absx cross cyc", cycles, 1);
        chk("R2 absx npc", next_pc, 16'h8002);
        run_op(4'd5, 8'hF0, 8'h12, 8'h05, 8'h00, 16'h8000, 1, 0);
        chk("R2 absx same ea", ea, 16'h12F5);
        chk("R3 absx same cyc", cycles, 0);
        run_op(4'd6, 8'hF0, 8'hFF, 8'h77, 8'h20, 16'h8000, 1, 0);
        chk("R2 absy wrap ea", ea, 16'h0010);
        chk("R3 absy wrap cyc", cycles, 1);
        run_op(4'd5, 8'h00, 8'h40, 8'h01, 8'h00, 16'h8000, 0, 0);
        chk("R4 absx store ea", ea, 16'h4001);
        chk("R4 absx store cyc", cycles, 1);
        run_op(4'd6, 8'h10, 8'h40, 8'h00, 8'h00, 16'h8000, 0, 0);
        chk("R4 absy store zero idx cyc", cycles, 1);
    endtask

    task automatic t_zp_indexed;
        run_op(4'd2, 8'hF0, 8'h33, 8'h20, 8'h00, 16'h8000, 1, 0);
        chk("R5 zpx wrap ea", ea, 16'h0010);
        chk("R5 zpx cyc", cycles, 0);
        run_op(4'd3, 8'h80, 8'h33, 8'h00, 8'h7F, 16'h8000, 1, 0);
        chk("R5 zpy ea", ea, 16'h00FF);
        run_op(4'd3, 8'hFF, 8'h33, 8'h00, 8'h02, 16'h8000, 1, 0);
        chk("R5 zpy wrap ea", ea, 16'h0001);
    endtask

    task automatic t_ind_x;
        zpmem[8'h45] = 8'hCD; zpmem[8'h46] = 8'hAB;
        mem_lat = 0;
        run_op(4'd7, 8'h40, 8'h00, 8'h05, 8'h00, 16'h8100, 1, 0);
        chk("R6 indx ea", ea, 16'hABCD);
        chk("R6 indx cyc", cycles, 0);
        chk("R6 indx npc", next_pc, 16'h8101);
        chk("R11 first read addr", rd_log[0], 8'h45);
        chk("R11 second read addr", rd_log[1], 8'h46);
        zpmem[8'hFF] = 8'h21; zpmem[8'h00] = 8'h43;
        mem_lat = 3;
        run_op(4'd7, 8'hFE, 8'h00, 8'h01, 8'h00, 16'h8100, 1, 0);
        chk("R8 indx wrap ea", ea, 16'h4321);
        chk("R8 indx wrap hi addr", rd_log[1], 8'h00);
        chk("R11 read count", nlog, 2);
        mem_lat = 0;
    endtask

    task automatic t_ind_y;
        zpmem[8'h20] = 8'hF8; zpmem[8'h21] = 8'h30;
        mem_lat = 2;
        run_op(4'd8, 8'h20, 8'h00, 8'h99, 8'h10, 16'h8200, 1, 0);
        chk("R7 indy cross ea", ea, 16'h3108);
        chk("R3 indy cross cyc", cycles, 1);
        chk("R7 indy npc", next_pc, 16'h8201);
        run_op(4'd8, 8'h20, 8'h00, 8'h99, 8'h03, 16'h8200, 1, 0);
        chk("R7 indy same ea", ea, 16'h30FB);
        chk("R3 indy same cyc", cycles, 0);
        run_op(4'd8, 8'h20, 8'h00, 8'h99, 8'h03, 16'h8200, 0, 0);
        chk("R4 indy store cyc", cycles, 1);
        zpmem[8'hFF] = 8'h00; zpmem[8'h00] = 8'h02;
        mem_lat = 0;
        run_op(4'd8, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h8200, 1, 0);
        chk("R8 indy wrap ea", ea, 16'h0200);
        zpmem[8'h50] = 8'hFF; zpmem[8'h51] = 8'hFF;
        run_op(4'd8, 8'h50, 8'h00, 8'h00, 8'h02, 16'h8200, 1, 0);
        chk("R7 indy 16-bit wrap ea", ea, 16'h0001);
    endtask

    task automatic t_branch;
        run_op(4'd9, 8'h10, 8'h00, 8'h00, 8'h00, 16'h8010, 1, 0);
        chk("R9 not taken npc", next_pc, 16'h8011);
        chk("R9 not taken cyc", cycles, 2);
        run_op(4'd9, 8'h10, 8'h00, 8'h00, 8'h00, 16'h8010, 1, 1);
        chk("R10 fwd target", next_pc, 16'h8021);
        chk("R10 fwd ea", ea, 16'h8021);
        chk("R10 fwd cyc", cycles, 3);
        run_op(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h8010, 1, 1);
        chk("R10 back cross target", next_pc, 16'h7F91);
        chk("R10 back cross cyc", cycles, 4);
        run_op(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 16'h80F0, 1, 1);
        chk("R10 fwd cross target", next_pc, 16'h8111);
        chk("R10 fwd cross cyc", cycles, 4);
        run_op(4'd9, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h8050, 1, 1);
        chk("R10 back same target", next_pc, 16'h804F);
        chk("R10 back same cyc", cycles, 3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) zpmem[i] = 8'(i * 3 + 1);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_direct();
        t_abs_indexed();
        t_zp_indexed();
        t_ind_x();
        t_ind_y();
        t_branch();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule